// File: doc/BRIEF.md
# Banked Register-File Word Address Remapper

This block sits between a processor core and its 1024-byte on-chip register RAM. For every operand access the core presents a register address, an access size (byte or word) and two configuration inputs: whether the system is built with a single memory bank or with several, and the status-word bit (bit 9) that picks the active bank pair. The block resolves the physical register address, reads the operand combinationally from that address, and, when write-enable is asserted, stores the operand on the next rising clock edge.

Byte operands and even word operands use the address as given. Odd word addresses are where the configurations differ. With a single bank, bit 0 is dropped and the word is taken at the even address below. With several banks, bit 0 redirects the access to the odd bank of the selected pair. That bank sits 0x100 above the pair's base, and the result wraps inside the 0x400-byte space. So in multi-bank mode, word 0x3B and word 0x13A name the same storage. With a single bank they are separate words.

Words are little-endian: the low byte is at the resolved even address and the high byte is at the next address up. The resolved address is also driven out on a port. The access port is a plain, always-ready port. It has no handshake and no back-pressure, because every access completes in the cycle it is presented.

Top module: `regbank_remap_top`

## Requirements
- R1: After reset is released, every register byte reads as zero until it is written.
- R2: A byte access (`acc_word_i`=0) resolves to `addr_i` unchanged, in both bank configurations and for either pair-select value.
- R3: A word access to an even address resolves to `addr_i` unchanged, in both configurations.
- R4: In single-bank mode (`multi_bank_i`=0), a word access to an odd address resolves to `addr_i` with bit 0 cleared (0x3B gives 0x3A).
- R5: In multi-bank mode with `pair_sel_i`=0, a word access to an odd address resolves to (`addr_i` with bit 0 cleared) + 0x100, modulo 0x400 (0x3B gives 0x13A).
- R6: In multi-bank mode with `pair_sel_i`=1, a word access to an odd address resolves to (`addr_i` with bit 0 cleared) + 0x300, modulo 0x400.
- R7: Reads are combinational from the resolved address P. A word read returns {byte[P+1], byte[P]}. A byte read returns {8'h00, byte[P]}.
- R8: With `wr_en_i`=1, the rising edge stores bytes at the resolved address. For a word access, `wr_be_i[0]` writes `wr_data_i[7:0]` to P and `wr_be_i[1]` writes `wr_data_i[15:8]` to P+1. For a byte access, `wr_be_i[0]` writes `wr_data_i[7:0]` to P, and `wr_be_i[1]` and `wr_data_i[15:8]` have no effect.
- R9: With `wr_en_i`=0, no register byte changes.
- R10: In single-bank mode, words 0x3B and 0x13A are distinct storage. In multi-bank mode with `pair_sel_i`=0, a write through one is read back through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset; clears the register RAM |
| multi_bank_i | input | 1 | 1 = system has several memory banks; 0 = single bank |
| pair_sel_i | input | 1 | Status-word bit 9; selects bank pair 0/1 (0) or 2/3 (1) |
| acc_word_i | input | 1 | 1 = word operand, 0 = byte operand |
| addr_i | input | 10 | Register address from the core |
| wr_en_i | input | 1 | Write strobe for this access |
| wr_be_i | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| wr_data_i | input | 16 | Write operand |
| rd_data_o | output | 16 | Read operand from the resolved address |
| phys_addr_o | output | 10 | Resolved physical register address |

## Verification
Address resolution and a write can fall in the same cycle. The write must land at the address resolved in that cycle, while the combinational read still shows the old contents until the edge. The bench provokes this with random streams that mix modes, pair selects, access sizes and byte enables every cycle, and it repeatedly targets odd word addresses so that writes land on aliased locations. A behavioural byte-array model applies each write at the edge using the mode the model itself computes. Both the read operand and the resolved address are compared on every falling edge, so a write that goes to the wrong alias shows up as a data mismatch on a later read.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  typedef enum logic {BANKS_SINGLE = 1'b0, BANKS_MULTI = 1'b1} bank_cfg_e;
  typedef enum logic {ACC_BYTE = 1'b0, ACC_WORD = 1'b1} acc_size_e;
  localparam int unsigned LANES = 2;
endpackage

// File: rtl/regbank_addr_map.sv
module regbank_addr_map
  import regmap_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic                     multi_bank_i,
  input  logic                     pair_sel_i,
  input  logic                     acc_word_i,
  input  logic [$clog2(DEPTH)-1:0] addr_i,
  output logic [$clog2(DEPTH)-1:0] phys_o
);
  localparam int unsigned AW        = $clog2(DEPTH);
  localparam int unsigned ODD_OFF   = DEPTH / 4;
  localparam int unsigned PAIR_SPAN = DEPTH / 2;

  logic [AW-1:0] aligned;
  logic [AW-1:0] pair_base;
  logic [AW:0]   redirect_sum;
  bank_cfg_e     cfg;
  acc_size_e     size;

  always_comb begin
    cfg          = bank_cfg_e'(multi_bank_i);
    size         = acc_size_e'(acc_word_i);
    aligned      = {addr_i[AW-1:1], 1'b0};
    pair_base    = pair_sel_i ? AW'(PAIR_SPAN) : '0;
    redirect_sum = {1'b0, aligned} + {1'b0, pair_base} + (AW+1)'(ODD_OFF);
    if (size == ACC_BYTE || !addr_i[0])
      phys_o = addr_i;
    else if (cfg == BANKS_SINGLE)
      phys_o = aligned;
    else
      phys_o = redirect_sum[AW-1:0];
  end
endmodule

// File: rtl/regbank_ram.sv
module regbank_ram
  import regmap_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] lane_addr_i [LANES],
  input  logic [LANES-1:0]         lane_we_i,
  input  logic [7:0]               lane_wdata_i [LANES],
  output logic [7:0]               lane_rdata_o [LANES]
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (lane_we_i[l]) mem[lane_addr_i[l]] <= lane_wdata_i[l];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign lane_rdata_o[l] = mem[lane_addr_i[l]];
  end
endmodule

// File: rtl/regbank_remap_top.sv
module regbank_remap_top
  import regmap_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          multi_bank_i,
  input  logic          pair_sel_i,
  input  logic          acc_word_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_be_i,
  input  logic [15:0]   wr_data_i,
  output logic [15:0]   rd_data_o,
  output logic [AW-1:0] phys_addr_o
);
  logic [AW-1:0]    phys;
  logic [AW-1:0]    lane_addr  [LANES];
  logic [LANES-1:0] lane_we;
  logic [7:0]       lane_wdata [LANES];
  logic [7:0]       lane_rdata [LANES];

  regbank_addr_map #(.DEPTH(DEPTH)) u_map (
    .multi_bank_i (multi_bank_i),
    .pair_sel_i   (pair_sel_i),
    .acc_word_i   (acc_word_i),
    .addr_i       (addr_i),
    .phys_o       (phys)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_lo
      assign lane_addr[l] = phys;
      assign lane_we[l]   = wr_en_i && wr_be_i[l];
    end else begin : g_hi
      assign lane_addr[l] = {phys[AW-1:1], 1'b1};
      assign lane_we[l]   = wr_en_i && wr_be_i[l] && acc_word_i;
    end
    assign lane_wdata[l] = wr_data_i[8*l +: 8];
  end

  regbank_ram #(.DEPTH(DEPTH)) u_ram (
    .clk          (clk),
    .rst_n        (rst_n),
    .lane_addr_i  (lane_addr),
    .lane_we_i    (lane_we),
    .lane_wdata_i (lane_wdata),
    .lane_rdata_o (lane_rdata)
  );

  assign rd_data_o   = acc_word_i ? {lane_rdata[1], lane_rdata[0]} : {8'h00, lane_rdata[0]};
  assign phys_addr_o = phys;
endmodule

// File: rtl/regbank_remap_chk.sv
module regbank_remap_chk #(
  parameter int unsigned AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          multi_bank_i,
  input logic          pair_sel_i,
  input logic          acc_word_i,
  input logic [AW-1:0] addr_i,
  input logic          wr_en_i,
  input logic [1:0]    wr_be_i,
  input logic [15:0]   wr_data_i,
  input logic [15:0]   rd_data_o,
  input logic [AW-1:0] phys_addr_o
);
  logic [AW-1:0] delta;
  assign delta = phys_addr_o - {addr_i[AW-1:1], 1'b0};

  p_byte_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_word_i |-> phys_addr_o == addr_i);

  p_even_word_identity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_word_i && !addr_i[0]) |-> phys_addr_o == addr_i);

  p_single_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_word_i && addr_i[0] && !multi_bank_i) |-> delta == '0);

  p_multi_pair0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_word_i && addr_i[0] && multi_bank_i && !pair_sel_i) |-> delta == AW'(1 << (AW-2)));

  p_multi_pair1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_word_i && addr_i[0] && multi_bank_i && pair_sel_i) |-> delta == AW'(3 << (AW-2)));

  p_byte_read_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_word_i |-> rd_data_o[15:8] == 8'h00);

  p_word_write_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && acc_word_i && wr_be_i == 2'b11) |=>
      (!($stable(addr_i) && $stable(acc_word_i) && $stable(multi_bank_i) && $stable(pair_sel_i))
       || rd_data_o == $past(wr_data_i)));

  p_no_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=>
      (!($stable(addr_i) && $stable(acc_word_i) && $stable(multi_bank_i) && $stable(pair_sel_i))
       || $stable(rd_data_o)));
endmodule

bind regbank_remap_top regbank_remap_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .multi_bank_i (multi_bank_i),
  .pair_sel_i   (pair_sel_i),
  .acc_word_i   (acc_word_i),
  .addr_i       (addr_i),
  .wr_en_i      (wr_en_i),
  .wr_be_i      (wr_be_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .phys_addr_o  (phys_addr_o)
);

// File: tb/regbank_remap_top_bench.sv
module regbank_remap_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        multi_bank_i = 1'b0;
  logic        pair_sel_i = 1'b0;
  logic        acc_word_i = 1'b0;
  logic [9:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_be_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic [9:0]  phys_addr_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [7:0] ref_mem [1024];

  always #5 clk = ~clk;

  regbank_remap_top u_regbank_remap_top (
    .clk (clk), .rst_n (rst_n), .multi_bank_i (multi_bank_i), .pair_sel_i (pair_sel_i),
    .acc_word_i (acc_word_i), .addr_i (addr_i), .wr_en_i (wr_en_i), .wr_be_i (wr_be_i),
    .wr_data_i (wr_data_i), .rd_data_o (rd_data_o), .phys_addr_o (phys_addr_o)
  );

  function automatic int ref_phys(bit multi, bit pair, bit word, int a);
    if (!word || (a % 2) == 0) return a;
    if (!multi) return a - 1;
    return (a - 1 + 256 + (pair ? 512 : 0)) % 1024;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (addr=%0h word=%0b multi=%0b pair=%0b)",
               req, actual, expected, addr_i, acc_word_i, multi_bank_i, pair_sel_i);
    end
  endtask

  task automatic compare(string data_req);
    int p, exp_data;
    string areq;
    p = ref_phys(multi_bank_i, pair_sel_i, acc_word_i, int'(addr_i));
    if (!acc_word_i) areq = "R2";
    else if (!addr_i[0]) areq = "R3";
    else if (!multi_bank_i) areq = "R4";
    else if (!pair_sel_i) areq = "R5";
    else areq = "R6";
    check(areq, int'(phys_addr_o), p);
    exp_data = acc_word_i ? ((int'(ref_mem[p + 1]) << 8) | int'(ref_mem[p])) : int'(ref_mem[p]);
    check(data_req, int'(rd_data_o), exp_data);
  endtask

  task automatic model_edge();
    int p;
    p = ref_phys(multi_bank_i, pair_sel_i, acc_word_i, int'(addr_i));
    if (wr_en_i) begin
      if (wr_be_i[0]) ref_mem[p] = wr_data_i[7:0];
      if (wr_be_i[1] && acc_word_i) ref_mem[p + 1] = wr_data_i[15:8];
    end
  endtask

  // one access: compare at falling edge, apply model at rising edge
  task automatic access(bit multi, bit pair, bit word, int a, bit we, bit [1:0] be,
                        bit [15:0] d, string data_req);
    multi_bank_i = multi; pair_sel_i = pair; acc_word_i = word;
    addr_i = 10'(a); wr_en_i = we; wr_be_i = be; wr_data_i = d;
    @(negedge clk);
    compare(data_req);
    @(posedge clk);
    model_edge();
    #1;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ref_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset contents
    for (int a = 0; a < 1024; a += 97) access(0, 0, 1, a & ~1, 0, 2'b00, 16'h0, "R1");

    // R10: alias behaviour of 0x3B and 0x13A
    access(0, 0, 1, 'h13A, 1, 2'b11, 16'hA55A, "R8");
    access(0, 0, 1, 'h3B, 1, 2'b11, 16'h1234, "R8");
    access(0, 0, 1, 'h13A, 0, 2'b00, 16'h0, "R10");
    check("R10", int'(rd_data_o), 'hA55A);
    access(1, 0, 1, 'h3B, 1, 2'b11, 16'hBEEF, "R8");
    access(1, 0, 1, 'h13A, 0, 2'b00, 16'h0, "R10");
    check("R10", int'(rd_data_o), 'hBEEF);

    // R6 wrap: odd word near top with pair 1
    access(1, 1, 1, 'h3FF, 1, 2'b11, 16'hC0DE, "R8");
    check("R6", int'(phys_addr_o), 'h2FE);
    access(1, 1, 1, 'h0FF, 0, 2'b00, 16'h0, "R7");
    check("R6", int'(phys_addr_o), 'h3FE);

    // R8: byte access ignores high enable
    access(0, 0, 0, 'h051, 1, 2'b11, 16'h7788, "R8");
    access(0, 0, 1, 'h050, 0, 2'b00, 16'h0, "R8");
    check("R8", int'(rd_data_o), 'h8800);

    // R8: partial word enables
    access(1, 0, 1, 'h061, 1, 2'b10, 16'h99AA, "R8");
    access(1, 0, 1, 'h061, 1, 2'b01, 16'h1122, "R8");
    access(0, 0, 1, 'h160, 0, 2'b00, 16'h0, "R8");
    check("R8", int'(rd_data_o), 'h9922);

    // R9: disabled write
    access(0, 1, 1, 'h200, 0, 2'b11, 16'hFFFF, "R9");
    access(0, 1, 1, 'h200, 0, 2'b00, 16'h0, "R9");

    // mixed random stream, odd addresses favoured
    for (int n = 0; n < 3000; n++) begin
      int a;
      a = int'($urandom_range(0, 1023));
      if ($urandom_range(0, 1) == 1) a = a | 1;
      if ($urandom_range(0, 3) == 0) a = (a & 'h0FF) | 1;
      access(1'($urandom), 1'($urandom), 1'($urandom), a, 1'($urandom),
             2'($urandom), 16'($urandom), "R7");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule